// File: doc/BRIEF.md
# SMBus EEPROM target

This block is the storage side of an SMBus host model. The host controller hands it one abstract transaction per request: a 7-bit target address, a direction bit, a protocol code, a command byte and a data byte. The block decodes eight consecutive target addresses starting at 0x50. Each address owns a private 256-byte bank and a private 8-bit offset pointer. Storage is synchronous RAM, so every answer comes back one clock after its request.

Two access styles share each bank. The byte-only protocols work through the offset pointer: a send byte loads the pointer, and a receive byte reads from the pointer and then advances it. The command-addressed protocols reach any byte directly and leave the pointer alone. A quick command is acknowledged and does nothing. Word, block and every unassigned protocol code are acknowledged with an unsupported flag, and the host turns that flag into its error bit. An address outside the window gets no acknowledge at all.

Top module: `smbus_eeprom_target`

## Requirements
- R1: A request to an address from 0x50 to 0x57 raises ack_o for exactly the one cycle after the request. Any other address, or a cycle with no request, leaves ack_o low in the next cycle.
- R2: Send byte (req_proto_i = 1, req_read_i = 0) loads req_cmd_i into the addressed bank's offset pointer and leaves memory unchanged.
- R3: Receive byte (req_proto_i = 1, req_read_i = 1) returns the byte at the bank's offset on rdata_o in the ack cycle, then increments the offset. The offset wraps from 255 to 0.
- R4: Write byte (req_proto_i = 2, req_read_i = 0) stores req_data_i at byte req_cmd_i of the addressed bank and leaves the offset pointer unchanged.
- R5: Read byte (req_proto_i = 2, req_read_i = 1) returns byte req_cmd_i of the addressed bank on rdata_o in the ack cycle and leaves the offset pointer unchanged.
- R6: Quick command (req_proto_i = 0, either direction) is acknowledged with unsup_o low and changes neither memory nor offset.
- R7: Word (code 3), block (code 5) and the unassigned codes 4, 6 and 7 are acknowledged with unsup_o high and change neither memory nor offset. unsup_o is low in every cycle where ack_o is low.
- R8: Each of the eight addresses has its own bank and its own offset pointer. An access to one address never affects another.
- R9: After reset every offset pointer is 0 and every byte of every bank reads as 0.
- R10: rdata_o is 0 in every cycle that is not the ack cycle of a receive byte or a read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle transaction request |
| req_addr_i | input | 7 | 7-bit target address |
| req_read_i | input | 1 | Direction: 1 = read, 0 = write |
| req_proto_i | input | 3 | Protocol: 0 quick, 1 byte, 2 byte with command, 3 word, 5 block |
| req_cmd_i | input | 8 | Command byte (memory location, or new offset for send byte) |
| req_data_i | input | 8 | Write data for write byte |
| ack_o | output | 1 | Acknowledge, one cycle after an in-window request |
| unsup_o | output | 1 | Unsupported protocol, valid with ack_o |
| rdata_o | output | 8 | Read data, valid in the ack cycle of a read |

## Verification
The checker watches the handshake on every cycle. It confirms that only an in-window request produces the acknowledge one cycle later, and that the unsupported flag follows the protocol code and never appears without ack_o. It also confirms that read data stays zero except after a read request. The bank contents and pointers cannot be seen from the ports on any one cycle. The bench's scenarios show them: offset wrap, the pointer staying put across command-addressed access, isolation between banks, and unsupported or quick operations leaving memory untouched. These are all checked against a bench model under random traffic.

// File: rtl/smbus_eeprom_pkg.sv
package smbus_eeprom_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned BANK_DEPTH = 2 ** BYTE_W;

  localparam logic [2:0] PROTO_QUICK     = 3'd0;
  localparam logic [2:0] PROTO_BYTE      = 3'd1;
  localparam logic [2:0] PROTO_BYTE_DATA = 3'd2;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_QUICK,
    OP_SEND,
    OP_RECV,
    OP_WR,
    OP_RD,
    OP_UNSUP
  } op_e;
endpackage

// File: rtl/smbus_eeprom_decode.sv
module smbus_eeprom_decode
  import smbus_eeprom_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h50,
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              req_i,
  input  logic [6:0]        addr_i,
  input  logic              read_i,
  input  logic [2:0]        proto_i,
  output logic [BANK_W-1:0] bank_o,
  output op_e               op_o
);
  logic hit;

  assign hit    = addr_i[6:BANK_W] == BASE_ADDR[6:BANK_W];
  assign bank_o = addr_i[BANK_W-1:0];

  always_comb begin
    op_o = OP_NONE;
    if (req_i && hit) begin
      unique case (proto_i)
        PROTO_QUICK:     op_o = OP_QUICK;
        PROTO_BYTE:      op_o = read_i ? OP_RECV : OP_SEND;
        PROTO_BYTE_DATA: op_o = read_i ? OP_RD : OP_WR;
        default:         op_o = OP_UNSUP;
      endcase
    end
  end
endmodule

// File: rtl/smbus_eeprom_bank.sv
module smbus_eeprom_bank
  import smbus_eeprom_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  op_e               op_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0]     mem [BANK_DEPTH];
  logic [BANK_DEPTH-1:0] written_q;   // stands in for a reset sweep of the RAM
  logic [BYTE_W-1:0]     off_q;
  logic [BYTE_W-1:0]     rd_raw_q;
  logic                  rd_vld_q;
  logic [BYTE_W-1:0]     idx;
  logic                  do_wr, do_rd;

  assign idx   = (op_i == OP_RECV) ? off_q : cmd_i;
  assign do_wr = sel_i && (op_i == OP_WR);
  assign do_rd = sel_i && ((op_i == OP_RECV) || (op_i == OP_RD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
    end else if (sel_i && op_i == OP_SEND) begin
      off_q <= cmd_i;
    end else if (sel_i && op_i == OP_RECV) begin
      off_q <= off_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q <= '0;
      rd_vld_q  <= 1'b0;
    end else begin
      if (do_wr) written_q[cmd_i] <= 1'b1;
      rd_vld_q <= do_rd && written_q[idx];
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[cmd_i] <= wdata_i;
    rd_raw_q <= mem[idx];
  end

  assign rdata_o = rd_vld_q ? rd_raw_q : '0;
endmodule

// File: rtl/smbus_eeprom_target.sv
module smbus_eeprom_target
  import smbus_eeprom_pkg::*;
#(
  parameter logic [6:0]  BASE_ADDR = 7'h50,
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [6:0] req_addr_i,
  input  logic       req_read_i,
  input  logic [2:0] req_proto_i,
  input  logic [7:0] req_cmd_i,
  input  logic [7:0] req_data_i,
  output logic       ack_o,
  output logic       unsup_o,
  output logic [7:0] rdata_o
);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);

  op_e               op_d;
  logic [BANK_W-1:0] bank_d, bank_q;
  logic              ack_q, unsup_q;
  logic [7:0]        bank_rd [NUM_BANKS];

  smbus_eeprom_decode #(
    .BASE_ADDR (BASE_ADDR),
    .NUM_BANKS (NUM_BANKS)
  ) i_decode (
    .req_i   (req_i),
    .addr_i  (req_addr_i),
    .read_i  (req_read_i),
    .proto_i (req_proto_i),
    .bank_o  (bank_d),
    .op_o    (op_d)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (op_d != OP_NONE) && (bank_d == BANK_W'(g));
    smbus_eeprom_bank i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel),
      .op_i    (op_d),
      .cmd_i   (req_cmd_i),
      .wdata_i (req_data_i),
      .rdata_o (bank_rd[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      unsup_q <= 1'b0;
      bank_q  <= '0;
    end else begin
      ack_q   <= op_d != OP_NONE;
      unsup_q <= op_d == OP_UNSUP;
      if (op_d != OP_NONE) bank_q <= bank_d;
    end
  end

  assign ack_o   = ack_q;
  assign unsup_o = unsup_q;
  assign rdata_o = bank_rd[bank_q];
endmodule

// File: rtl/smbus_eeprom_target_chk.sv
module smbus_eeprom_target_chk #(
  parameter logic [6:0]  BASE_ADDR = 7'h50,
  parameter int unsigned NUM_BANKS = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [6:0] req_addr_i,
  input logic       req_read_i,
  input logic [2:0] req_proto_i,
  input logic       ack_o,
  input logic       unsup_o,
  input logic [7:0] rdata_o
);
  localparam int unsigned BANK_W = $clog2(NUM_BANKS);

  logic in_win, bad_proto, is_read;
  assign in_win    = req_i && (req_addr_i[6:BANK_W] == BASE_ADDR[6:BANK_W]);
  assign bad_proto = req_proto_i > 3'd2;
  assign is_read   = req_read_i && (req_proto_i == 3'd1 || req_proto_i == 3'd2);

  AST_ACK_AFTER_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_win |=> ack_o); // R1
  AST_NO_ACK_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |=> !ack_o); // R1
  AST_UNSUP_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && bad_proto) |=> unsup_o); // R7
  AST_SUPPORTED_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && !bad_proto) |=> !unsup_o); // R6
  AST_UNSUP_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> ack_o); // R7
  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_win && is_read) |=> rdata_o == 8'h00); // R10
endmodule

bind smbus_eeprom_target smbus_eeprom_target_chk #(
  .BASE_ADDR (BASE_ADDR),
  .NUM_BANKS (NUM_BANKS)
) i_chk (.*);

// File: tb/test_smbus_eeprom_target.sv
`timescale 1ns/1ps
module test_smbus_eeprom_target;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [6:0] req_addr_i = '0;
  logic       req_read_i = 1'b0;
  logic [2:0] req_proto_i = '0;
  logic [7:0] req_cmd_i = '0;
  logic [7:0] req_data_i = '0;
  logic       ack_o, unsup_o;
  logic [7:0] rdata_o;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;

  logic [7:0] mdl_mem [8][256];
  logic [7:0] mdl_off [8];

  always #2 clk_i = ~clk_i;

  smbus_eeprom_target i_smbus_eeprom_target (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive one request, predict its result from the model, check the ack cycle.
  task automatic xact(input logic [6:0] a, input logic rd, input logic [2:0] p,
                      input logic [7:0] c, input logic [7:0] d, input string tag);
    logic hit, e_ack, e_uns;
    logic [7:0] e_rd;
    int b;
    hit = a[6:3] == 4'hA;
    b = int'(a[2:0]);
    e_ack = hit; e_uns = 1'b0; e_rd = 8'h00;
    if (hit) begin
      case (p)
        3'd0: ;
        3'd1: if (rd) begin e_rd = mdl_mem[b][mdl_off[b]]; mdl_off[b] = mdl_off[b] + 8'd1; end
              else mdl_off[b] = c;
        3'd2: if (rd) e_rd = mdl_mem[b][c]; else mdl_mem[b][c] = d;
        default: e_uns = 1'b1;
      endcase
    end
    @(negedge clk_i);
    req_i = 1'b1; req_addr_i = a; req_read_i = rd; req_proto_i = p;
    req_cmd_i = c; req_data_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
    check({tag, " ack"}, int'(ack_o), int'(e_ack));
    check({tag, " unsup"}, int'(unsup_o), int'(e_uns));
    check({tag, " rdata"}, int'(rdata_o), int'(e_rd));
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk_i);
    check({tag, " idle ack"}, int'(ack_o), 0);
    check({tag, " idle rdata"}, int'(rdata_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) begin
      mdl_off[b] = 8'h00;
      for (int i = 0; i < 256; i++) mdl_mem[b][i] = 8'h00;
    end
    void'($urandom(32'd20070131));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9: outputs idle and memory reads zero after reset
    check("R9 reset ack", int'(ack_o), 0);
    check("R9 reset unsup", int'(unsup_o), 0);
    check("R9 reset rdata", int'(rdata_o), 0);
    xact(7'h50, 1'b1, 3'd2, 8'h10, 8'h00, "R9 read zero");
    xact(7'h57, 1'b1, 3'd2, 8'hFF, 8'h00, "R9 read zero top");
    // R9: pointer starts at 0
    xact(7'h53, 1'b0, 3'd2, 8'h00, 8'hA5, "R4 write b3");
    xact(7'h53, 1'b1, 3'd1, 8'h77, 8'h00, "R9 recv from offset 0");
    idle_check("R10");
    // R2/R3: load pointer near top, receive across wrap
    xact(7'h51, 1'b0, 3'd2, 8'hFE, 8'h11, "R4 write FE");
    xact(7'h51, 1'b0, 3'd2, 8'hFF, 8'h22, "R4 write FF");
    xact(7'h51, 1'b0, 3'd2, 8'h00, 8'h33, "R4 write 00");
    xact(7'h51, 1'b0, 3'd1, 8'hFE, 8'h00, "R2 send FE");
    xact(7'h51, 1'b1, 3'd2, 8'hFE, 8'h00, "R2 memory kept");
    xact(7'h51, 1'b1, 3'd1, 8'h00, 8'h00, "R3 recv FE");
    xact(7'h51, 1'b1, 3'd1, 8'h00, 8'h00, "R3 recv FF");
    xact(7'h51, 1'b1, 3'd1, 8'h00, 8'h00, "R3 recv wrap 00");
    // R4/R5: command access leaves pointer alone
    xact(7'h52, 1'b0, 3'd2, 8'h20, 8'h5A, "R4 write 20");
    xact(7'h52, 1'b0, 3'd1, 8'h20, 8'h00, "R2 send 20");
    xact(7'h52, 1'b0, 3'd2, 8'h40, 8'hC3, "R4 write 40");
    xact(7'h52, 1'b1, 3'd2, 8'h40, 8'h00, "R5 read 40");
    xact(7'h52, 1'b1, 3'd1, 8'h00, 8'h00, "R4 R5 pointer kept");
    // R6: quick command has no effect
    xact(7'h52, 1'b0, 3'd0, 8'h40, 8'hEE, "R6 quick write");
    xact(7'h52, 1'b1, 3'd0, 8'h40, 8'hEE, "R6 quick read");
    xact(7'h52, 1'b1, 3'd1, 8'h00, 8'h00, "R6 pointer kept");
    xact(7'h52, 1'b1, 3'd2, 8'h40, 8'h00, "R6 memory kept");
    // R7: word, block and unassigned codes
    for (int p = 3; p < 8; p++) begin
      xact(7'h54, 1'b0, 3'(p), 8'h05, 8'h99, "R7 unsup write");
      xact(7'h54, 1'b1, 3'(p), 8'h05, 8'h99, "R7 unsup read");
    end
    xact(7'h54, 1'b1, 3'd2, 8'h05, 8'h00, "R7 memory kept");
    xact(7'h54, 1'b1, 3'd1, 8'h00, 8'h00, "R7 pointer kept");
    // R1: out-of-window addresses
    xact(7'h4F, 1'b0, 3'd2, 8'h01, 8'h12, "R1 miss 4F");
    xact(7'h58, 1'b1, 3'd2, 8'h01, 8'h00, "R1 miss 58");
    xact(7'h00, 1'b1, 3'd1, 8'h00, 8'h00, "R1 miss 00");
    idle_check("R1");
    // R8: same location, distinct banks
    for (int b = 0; b < 8; b++) xact(7'(8'h50 + b), 1'b0, 3'd2, 8'h80, 8'(b * 17 + 1), "R8 write");
    for (int b = 0; b < 8; b++) xact(7'(8'h50 + b), 1'b0, 3'd1, 8'(b + 8'h80), 8'h00, "R8 send");
    for (int b = 7; b >= 0; b--) xact(7'(8'h50 + b), 1'b1, 3'd2, 8'h80, 8'h00, "R8 read");
    for (int b = 0; b < 8; b++) xact(7'(8'h50 + b), 1'b1, 3'd1, 8'h00, 8'h00, "R8 recv");
    // Random traffic against the model (R1-style mix of all operations)
    for (int n = 0; n < 400; n++) begin
      logic [6:0] a;
      logic [7:0] c;
      logic [2:0] p;
      a = 7'(7'h4C + ($urandom % 16));
      p = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'(1 + ($urandom % 2));
      c = ($urandom % 2 == 1) ? 8'($urandom % 6) : 8'(8'hFA + ($urandom % 6));
      xact(a, 1'($urandom % 2), p, c, 8'($urandom), "R3 R5 random");
    end
    idle_check("R10 end");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule